// File: doc/BRIEF.md
# Boot Strap Pin Sampler

This block sits on the device side of a chip and takes the boot strap reading once. It watches three strap pads and an active-low external reset. When that reset is released, it records the three pad levels as a 3-bit boot-select code and holds the code until the next external reset release. A watchdog reset request puts the chip back into reset, but it does not take a new reading, so the boot code chosen at the last external release stays in effect. From the held code the block derives a UART-boot flag, and it marks each new capture with a one-cycle valid strobe.

The block also decides what drives strap pad 1, the pad shared with firmware. While the chip is held in reset, from the external reset or from a watchdog hold window, the block forces that pad's output enable off and its weak pull-up on. Outside reset, the firmware's own enable and pull-up settings pass through unchanged. Power-on reset `rst_ni` clears every register. With the default parameters, the pad inputs and the external reset each pass through a two-flop synchronizer before the block uses them.

Top module: `boot_strap_sampler`

## Requirements
- R1: `boot_sel_o[2]` takes its value from `strap2_i`, `boot_sel_o[1]` from `strap1_i` and `boot_sel_o[0]` from `strap0_i`.
- R2: The captured code equals the pad levels sampled at the first rising clock edge at which `ext_rst_ni` is seen high. `boot_sel_o` and `sel_valid_o` update at the third rising edge after `ext_rst_ni` rises.
- R3: Pad changes made while `ext_rst_ni` is low, or after the capture edge, do not alter `boot_sel_o`.
- R4: A pulse on `wdt_rst_req_i` leaves `boot_sel_o` unchanged and does not raise `sel_valid_o`.
- R5: `sel_valid_o` is high for exactly one cycle per external reset release.
- R6: `uart_boot_o` is high exactly when `boot_sel_o` equals 3'b001 (strap2 low, strap1 low, strap0 high).
- R7: While `ext_rst_ni` is low, `pad_oe_o` is 0 and `pad_pu_o` is 1, with no clock edge needed.
- R8: After a clock edge samples `wdt_rst_req_i` high, the override of R7 holds for WDT_HOLD_CYCLES cycles (default 16) and then lifts.
- R9: Outside any reset, `pad_oe_o` follows `fw_oe_i` and `pad_pu_o` follows `fw_pu_i`.
- R10: After power-on reset and before the first capture, `boot_sel_o` is 3'b000, and `sel_valid_o` and `uart_boot_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_ni | input | 1 | External reset pad, active low |
| wdt_rst_req_i | input | 1 | Watchdog reset request |
| strap2_i | input | 1 | Strap pad for select bit 2 |
| strap1_i | input | 1 | Shared strap pad for select bit 1 |
| strap0_i | input | 1 | Strap pad for select bit 0 |
| fw_oe_i | input | 1 | Firmware output enable for the shared pad |
| fw_pu_i | input | 1 | Firmware pull-up enable for the shared pad |
| boot_sel_o | output | 3 | Latched boot-select code |
| uart_boot_o | output | 1 | UART boot mode selected |
| sel_valid_o | output | 1 | One-cycle strobe on capture |
| pad_oe_o | output | 1 | Shared pad output enable |
| pad_pu_o | output | 1 | Shared pad weak pull-up enable |

## Verification
The hardest thing to show from the ports is that the capture uses one clock edge and only that edge. A design that samples a cycle early or a cycle late looks the same until the pads move right next to the release. To expose it, the stimulus drives the complement pattern while the reset is held and sets the intended pattern only just before the release. It then flips the pads one cycle after the release, so that a neighbouring sample would give a wrong code. The watchdog test drives pad levels that differ from the stored code throughout its hold window, so any re-sample would show up on `boot_sel_o`.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;
  localparam int unsigned SEL_W = 3;
  typedef logic [SEL_W-1:0] boot_sel_t;

  localparam boot_sel_t SEL_UART = 3'b001;

  function automatic logic sel_is_uart(boot_sel_t s);
    return s == SEL_UART;
  endfunction
endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
  parameter int unsigned WIDTH = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  localparam int unsigned N = (STAGES < 1) ? 1 : STAGES;

  logic [N-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= {N{RST_VAL}};
    end else begin
      stage_q[0] <= d_i;
      for (int i = 1; i < int'(N); i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q_o = stage_q[N-1];
endmodule

// File: rtl/strap_capture.sv
module strap_capture
  import boot_strap_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      rel_sync_i,
  input  boot_sel_t pins_sync_i,
  output boot_sel_t boot_sel_o,
  output logic      valid_o,
  output logic      uart_boot_o
);
  logic      rel_prev_q;
  logic      cap;
  boot_sel_t sel_q;
  logic      valid_q;

  // capture only on the release edge of external reset
  assign cap = rel_sync_i & ~rel_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rel_prev_q <= 1'b0;
      sel_q      <= '0;
      valid_q    <= 1'b0;
    end else begin
      rel_prev_q <= rel_sync_i;
      valid_q    <= cap;
      if (cap) sel_q <= pins_sync_i;
    end
  end

  assign boot_sel_o  = sel_q;
  assign valid_o     = valid_q;
  assign uart_boot_o = sel_is_uart(sel_q);

  // R3
  sel_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cap |=> $stable(sel_q));

  // R5
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_q |=> !valid_q);
endmodule

// File: rtl/reset_ctrl.sv
module reset_ctrl #(
  parameter int unsigned WDT_HOLD_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_rst_ni,
  input  logic rel_sync_i,
  input  logic wdt_req_i,
  input  logic fw_oe_i,
  input  logic fw_pu_i,
  output logic pad_oe_o,
  output logic pad_pu_o
);
  localparam int unsigned HOLD  = (WDT_HOLD_CYCLES < 1) ? 1 : WDT_HOLD_CYCLES;
  localparam int unsigned CNT_W = $clog2(HOLD + 1);

  logic [CNT_W-1:0] wdt_cnt_q;
  logic             in_reset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                wdt_cnt_q <= '0;
    else if (wdt_req_i)         wdt_cnt_q <= CNT_W'(HOLD);
    else if (wdt_cnt_q != '0)   wdt_cnt_q <= wdt_cnt_q - 1'b1;
  end

  // raw pad term gives override before the synchronizer catches up
  assign in_reset = ~ext_rst_ni | ~rel_sync_i | wdt_req_i | (wdt_cnt_q != '0);

  assign pad_oe_o = in_reset ? 1'b0 : fw_oe_i;
  assign pad_pu_o = in_reset ? 1'b1 : fw_pu_i;

  // R8
  wdt_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_req_i |=> (!pad_oe_o && pad_pu_o));
endmodule

// File: rtl/boot_strap_sampler.sv
module boot_strap_sampler
  import boot_strap_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WDT_HOLD_CYCLES = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_rst_ni,
  input  logic             wdt_rst_req_i,
  input  logic             strap2_i,
  input  logic             strap1_i,
  input  logic             strap0_i,
  input  logic             fw_oe_i,
  input  logic             fw_pu_i,
  output logic [SEL_W-1:0] boot_sel_o,
  output logic             uart_boot_o,
  output logic             sel_valid_o,
  output logic             pad_oe_o,
  output logic             pad_pu_o
);
  boot_sel_t pins_raw;
  boot_sel_t pins_sync;
  logic      rel_sync;

  assign pins_raw = {strap2_i, strap1_i, strap0_i};

  strap_sync #(.WIDTH(SEL_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_sync)
  );

  strap_sync #(.WIDTH(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rel_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ext_rst_ni),
    .q_o   (rel_sync)
  );

  strap_capture u_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rel_sync_i (rel_sync),
    .pins_sync_i(pins_sync),
    .boot_sel_o (boot_sel_o),
    .valid_o    (sel_valid_o),
    .uart_boot_o(uart_boot_o)
  );

  reset_ctrl #(.WDT_HOLD_CYCLES(WDT_HOLD_CYCLES)) u_reset_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_rst_ni(ext_rst_ni),
    .rel_sync_i(rel_sync),
    .wdt_req_i (wdt_rst_req_i),
    .fw_oe_i   (fw_oe_i),
    .fw_pu_i   (fw_pu_i),
    .pad_oe_o  (pad_oe_o),
    .pad_pu_o  (pad_pu_o)
  );

  // R6
  uart_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uart_boot_o != $past(uart_boot_o)) |-> sel_valid_o);

  // R7
  ext_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ext_rst_ni |-> (!pad_oe_o && pad_pu_o));

  // R4
  wdt_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_rst_req_i && ext_rst_ni && $past(ext_rst_ni)) |=> !sel_valid_o);
endmodule

// File: tb/sim_boot_strap_sampler.sv
module sim_boot_strap_sampler;
  localparam int HOLD = 16;

  logic       clk = 1'b0;
  logic       rst_ni, ext_rst_ni, wdt_req, fw_oe, fw_pu;
  logic [2:0] pins;
  logic [2:0] boot_sel;
  logic       uart_boot, sel_valid, pad_oe, pad_pu;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  boot_strap_sampler #(.SYNC_STAGES(2), .WDT_HOLD_CYCLES(HOLD)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .wdt_rst_req_i(wdt_req),
    .strap2_i(pins[2]), .strap1_i(pins[1]), .strap0_i(pins[0]),
    .fw_oe_i(fw_oe), .fw_pu_i(fw_pu),
    .boot_sel_o(boot_sel), .uart_boot_o(uart_boot), .sel_valid_o(sel_valid),
    .pad_oe_o(pad_oe), .pad_pu_o(pad_pu)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_por();
    rst_ni = 1'b0; ext_rst_ni = 1'b0; wdt_req = 1'b0;
    fw_oe = 1'b1; fw_pu = 1'b0; pins = 3'b001;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    chk("R10 sel", 8'(boot_sel), 8'h0);
    chk("R10 valid", 8'(sel_valid), 8'h0);
    chk("R10 uart", 8'(uart_boot), 8'h0);
    chk("R7 oe in reset", 8'(pad_oe), 8'h0);
    chk("R7 pu in reset", 8'(pad_pu), 8'h1);
  endtask

  task automatic t_release(input logic [2:0] p, input logic [2:0] prev);
    @(negedge clk);
    ext_rst_ni = 1'b0;
    #1;
    chk("R7 immediate oe", 8'(pad_oe), 8'h0);
    chk("R7 immediate pu", 8'(pad_pu), 8'h1);
    pins = ~p;
    repeat (3) begin
      @(negedge clk);
      pins = pins ^ 3'b101;
    end
    chk("R3 sel held during reset", 8'(boot_sel), 8'(prev));
    pins = p;
    @(negedge clk);
    ext_rst_ni = 1'b1;
    @(negedge clk);
    pins = ~p;
    @(negedge clk);
    chk("R2 no early valid", 8'(sel_valid), 8'h0);
    chk("R2 no early sel", 8'(boot_sel), 8'(prev));
    @(negedge clk);
    chk("R1 R2 captured code", 8'(boot_sel), 8'(p));
    chk("R5 valid high", 8'(sel_valid), 8'h1);
    chk("R6 uart flag", 8'(uart_boot), 8'(p == 3'b001));
    @(negedge clk);
    chk("R5 valid one cycle", 8'(sel_valid), 8'h0);
    chk("R9 oe passthrough", 8'(pad_oe), 8'(fw_oe));
    chk("R9 pu passthrough", 8'(pad_pu), 8'(fw_pu));
    repeat (4) begin
      @(negedge clk);
      pins = pins ^ 3'b011;
    end
    @(negedge clk);
    chk("R3 sel held after capture", 8'(boot_sel), 8'(p));
  endtask

  task automatic t_wdt();
    logic [2:0] s;
    int vcount;
    s = boot_sel;
    vcount = 0;
    fw_oe = 1'b1; fw_pu = 1'b0;
    pins = ~s;
    @(negedge clk);
    wdt_req = 1'b1;
    @(negedge clk);
    wdt_req = 1'b0;
    chk("R8 override start oe", 8'(pad_oe), 8'h0);
    chk("R8 override start pu", 8'(pad_pu), 8'h1);
    repeat (HOLD - 1) begin
      @(negedge clk);
      if (sel_valid) vcount++;
      pins = pins ^ 3'b110;
    end
    chk("R8 override last cycle", 8'(pad_oe), 8'h0);
    @(negedge clk);
    if (sel_valid) vcount++;
    chk("R8 override lifted oe", 8'(pad_oe), 8'h1);
    chk("R9 pu after wdt", 8'(pad_pu), 8'h0);
    repeat (4) begin
      @(negedge clk);
      if (sel_valid) vcount++;
    end
    chk("R4 sel kept after wdt", 8'(boot_sel), 8'(s));
    chk("R4 no valid on wdt", 8'(vcount), 8'h0);
  endtask

  initial begin
    t_por();
    t_release(3'b001, 3'b000);
    fw_oe = 1'b0; fw_pu = 1'b1;
    t_release(3'b110, 3'b001);
    fw_oe = 1'b1; fw_pu = 1'b0;
    t_release(3'b011, 3'b110);
    t_release(3'b101, 3'b011);
    t_wdt();
    t_release(3'b001, 3'b101);
    t_wdt();
    t_release(3'b000, 3'b001);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog timeout actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule